// File: doc/BRIEF.md
# Oversampling RZ Clock and Data Recovery

This block recovers bit timing and data from a slow return-to-zero serial line using a much faster local clock. Every one bit on the line is a pulse whose rising edge opens the bit cell. Every zero bit is a cell that stays low. The line is asynchronous, so it first passes through a two-stage synchroniser. A rising-edge detector then feeds an all-digital phase tracker.

The tracker keeps a phase counter that runs from 0 up to a programmable number of system clocks per bit and then wraps. Phase 0 is the expected cell boundary. When an edge arrives away from phase 0, the counter is retarded or advanced by exactly one count. When no edges arrive, for example during a run of zeros, the counter keeps its last phase and its nominal rate. At half the period it issues a one-cycle strobe. The recovered bit is 1 when a rising edge was seen since the previous strobe.

A lock monitor compares each edge against a window of one eighth of a bit around phase 0. It sets the lock flag after a run of edges inside the window and clears it after a run of edges outside it.

Top module: `rz_bit_recovery`

## Requirements
- R1: While reset is asserted and on release, data_o, valid_o and lock_o are all 0.
- R2: Only a low-to-high change of the line counts as an edge: a line held high across several bit cells yields a single 1 followed by 0s.
- R3: valid_o is a pulse of one cycle. With no edges, consecutive pulses are exactly period_i cycles apart. While locked, each interval is period_i - 1, period_i or period_i + 1 cycles.
- R4: Let phase p run from 0 to period_i - 1. An edge seen at p = 0 or p = period_i/2 causes no correction. An edge at 0 < p < period_i/2 holds the phase for one cycle (retard by one). An edge at p > period_i/2 steps it by two (advance by one). No edge ever moves the phase by more than one count.
- R5: At each valid_o pulse, data_o is 1 exactly when a rising edge was detected since the previous pulse, including the pulse cycle itself; otherwise it is 0.
- R6: For a transmit bit period within ±1/64 of period_i and zero runs that drift less than 4 clocks, every bit recovered while locked equals the transmitted bit.
- R7: lock_o rises on the eighth consecutive edge whose phase distance from 0 is at most period_i/8. With no edges, it never rises.
- R8: lock_o falls on the fourth consecutive edge outside that window. Any in-window edge restarts the count of out-of-window edges.
- R9: period_i is an even number of at least 8, changed only while reset is asserted. The strobe spacing and the recovered data follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, many times the bit rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Asynchronous return-to-zero serial input |
| period_i | input | PH_W | Nominal system clocks per bit (even, at least 8) |
| data_o | output | 1 | Recovered bit, valid with valid_o |
| valid_o | output | 1 | One-cycle mid-bit sample strobe |
| lock_o | output | 1 | Phase tracker is aligned to the line |

## Verification
The assertions assume that period_i is even, at least 8, and steady whenever reset is released. They also assume that line pulses last at least two system clocks, so the synchroniser never produces back-to-back edges. The stimulus sets the period only inside a reset window and keeps it constant for the whole run. It builds every one pulse as half a bit cell. Fractional transmit rates are made from an accumulator, so that cell lengths vary by at most one clock.

// File: rtl/rzcdr_pkg.sv
package rzcdr_pkg;

    // Correction applied to the phase counter on a detected edge.
    typedef enum logic [1:0] {
        CORR_NONE    = 2'd0,
        CORR_RETARD  = 2'd1,
        CORR_ADVANCE = 2'd2
    } corr_e;

endpackage

// File: rtl/rzcdr_edge_sync.sv
module rzcdr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic rise_o
);
    // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous level
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rise_o = sync_q.sh[STAGES-1] & ~sync_q.sh[STAGES];

    // R2: a detected rise is never followed by another rise in the next cycle
    assert_rise_isolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/rzcdr_phase_track.sv
module rzcdr_phase_track
    import rzcdr_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PH_W-1:0] period_i,
    input  logic            rise_i,
    output logic            strobe_o,
    output logic            bit_o,
    output logic            in_win_o
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            seen;
        logic            valid;
        logic            data;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [PH_W-1:0] half_len;
    logic [PH_W-1:0] last_ph;
    logic [PH_W-1:0] win_len;
    logic [PH_W-1:0] ring_dist;
    logic [PH_W:0]   step2;
    logic [PH_W:0]   period_x;
    logic            at_mid;
    corr_e           corr;

    always_comb begin
        half_len  = period_i >> 1;
        last_ph   = period_i - 1'b1;
        win_len   = period_i >> 3;
        ring_dist = (trk_q.ph <= half_len) ? trk_q.ph : (period_i - trk_q.ph);
        period_x  = {1'b0, period_i};
        step2     = {1'b0, trk_q.ph} + (PH_W+1)'(2);
        at_mid    = (trk_q.ph == half_len);

        corr = CORR_NONE;
        if (rise_i && (trk_q.ph != '0) && !at_mid) begin
            corr = (trk_q.ph < half_len) ? CORR_RETARD : CORR_ADVANCE;
        end

        trk_d = trk_q;
        case (corr)
            CORR_RETARD:  trk_d.ph = trk_q.ph;
            CORR_ADVANCE: trk_d.ph = (step2 >= period_x) ? PH_W'(step2 - period_x)
                                                         : step2[PH_W-1:0];
            default:      trk_d.ph = (trk_q.ph >= last_ph) ? '0 : trk_q.ph + 1'b1;
        endcase

        trk_d.valid = at_mid;
        if (at_mid) begin
            trk_d.data = trk_q.seen | rise_i;
            trk_d.seen = 1'b0;
        end else begin
            trk_d.seen = trk_q.seen | rise_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    assign strobe_o = trk_q.valid;
    assign bit_o    = trk_q.data;
    assign in_win_o = (ring_dist <= win_len);

    // R4: the phase never leaves its range
    assert_phase_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trk_q.ph < period_i);

    // R3: with no edge, the phase only steps by one or wraps to zero
    assert_free_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rise_i |=> ((trk_q.ph == '0) || (trk_q.ph == $past(trk_q.ph) + 1'b1)));

    // R3: the sample strobe lasts one cycle
    assert_strobe_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trk_q.valid |=> !trk_q.valid);

endmodule

// File: rtl/rzcdr_lock_mon.sv
module rzcdr_lock_mon #(
    parameter int LOCK_IN  = 8,
    parameter int LOCK_OUT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_i,
    input  logic win_i,
    output logic lock_o
);
    localparam int MAXC = (LOCK_IN > LOCK_OUT) ? LOCK_IN : LOCK_OUT;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic [CW-1:0] good;
        logic [CW-1:0] bad;
        logic          lock;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (edge_i) begin
            if (win_i) begin
                lk_d.bad = '0;
                if (int'(lk_q.good) < LOCK_IN)       lk_d.good = lk_q.good + 1'b1;
                if (int'(lk_q.good) + 1 >= LOCK_IN)  lk_d.lock = 1'b1;
            end else begin
                lk_d.good = '0;
                if (int'(lk_q.bad) < LOCK_OUT)       lk_d.bad = lk_q.bad + 1'b1;
                if (int'(lk_q.bad) + 1 >= LOCK_OUT)  lk_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) lk_q <= '0;
        else         lk_q <= lk_d;
    end

    assign lock_o = lk_q.lock;

    // R7: lock is only gained on an in-window edge
    assert_lock_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lk_q.lock) |-> $past(edge_i && win_i));

    // R8: lock is only lost on an out-of-window edge
    assert_lock_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lk_q.lock) |-> $past(edge_i && !win_i));

endmodule

// File: rtl/rz_bit_recovery.sv
module rz_bit_recovery #(
    parameter int PH_W     = 8,
    parameter int STAGES   = 2,
    parameter int LOCK_IN  = 8,
    parameter int LOCK_OUT = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            line_i,
    input  logic [PH_W-1:0] period_i,
    output logic            data_o,
    output logic            valid_o,
    output logic            lock_o
);
    logic rise;
    logic in_win;

    rzcdr_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i),
        .rise_o (rise)
    );

    rzcdr_phase_track #(.PH_W(PH_W)) u_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .period_i (period_i),
        .rise_i   (rise),
        .strobe_o (valid_o),
        .bit_o    (data_o),
        .in_win_o (in_win)
    );

    rzcdr_lock_mon #(.LOCK_IN(LOCK_IN), .LOCK_OUT(LOCK_OUT)) u_lock (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .edge_i (rise),
        .win_i  (in_win),
        .lock_o (lock_o)
    );

    // R9: the period setting is even and at least 8 outside reset
    assert_period_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i >= PH_W'(8)) && !period_i[0]);

    // R9: the period setting does not change outside reset
    assert_period_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(period_i));

endmodule

// File: tb/rz_bit_recovery_test.sv
module rz_bit_recovery_test;
    localparam int PH_W = 8;
    localparam int NV   = 7;
    localparam int QPER [NV] = '{64, 65, 63, 65, 63, 64, 96};
    localparam int PER  [NV] = '{16, 16, 16, 16, 16, 16, 24};
    localparam logic [31:0] PAT [NV] = '{
        32'h8000_0001, 32'hB00F_00D1, 32'h9001_2C03, 32'hFFFF_FFFF,
        32'h5555_AAAA, 32'h0100_0080, 32'hC3A5_0F12};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic [PH_W-1:0] period = 8'd16;
    logic data, valid, lock;

    always #4 clk = ~clk;

    rz_bit_recovery #(.PH_W(PH_W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .period_i(period),
        .data_o(data), .valid_o(valid), .lock_o(lock));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // strobe log
    int   logt [4096];
    logic logd [4096];
    logic logl [4096];
    int   nlog = 0;
    int   last_t = -1;
    logic last_l = 1'b0;
    int   sp_bad = 0;
    int   sp_worst = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            nlog   = 0;
            last_t = -1;
        end else if (valid) begin
            if (nlog < 4096) begin
                logt[nlog] = cyc;
                logd[nlog] = data;
                logl[nlog] = lock;
                nlog++;
            end
            if (last_t >= 0 && last_l && lock &&
                ((cyc - last_t) < int'(period) - 1 || (cyc - last_t) > int'(period) + 1)) begin
                sp_bad++;
                sp_worst = cyc - last_t;
            end
            last_t = cyc;
            last_l = lock;
        end
    end

    // transmit record
    int   tstart [512];
    logic tbit   [512];
    int   ntx = 0;
    int   tend = 0;
    int   acc = 0;
    int   done = 0;

    task automatic do_reset(input int per);
        rst_n  = 1'b0;
        line   = 1'b0;
        period = PH_W'(per);
        ntx = 0; acc = 0; done = 0; tend = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_cell(input logic b, input int len, input int hi);
        tstart[ntx] = cyc;
        tbit[ntx]   = b;
        ntx++;
        for (int i = 0; i < len; i++) begin
            line = (i < hi);
            @(negedge clk);
        end
        line = 1'b0;
        tend = cyc;
    endtask

    task automatic put_bit(input logic b, input int qper);
        int len;
        acc  += qper;
        len   = acc / 4 - done;
        done += len;
        put_cell(b, len, b ? len / 2 : 0);
    endtask

    task automatic score(input string tag, input int minc);
        int mism = 0;
        int cmp  = 0;
        int off  = int'(period) / 2 - 2;
        for (int i = 0; i < nlog; i++) begin
            if (logl[i]) begin
                int tref = logt[i] - off;
                if (ntx > 0 && tref >= tstart[0] && tref < tend) begin
                    int k = 0;
                    for (int j = 0; j < ntx; j++) if (tstart[j] <= tref) k = j;
                    cmp++;
                    if (logd[i] !== tbit[k]) mism++;
                end
            end
        end
        check(mism == 0, {tag, " recovered bit mismatches"}, mism, 0);
        check(cmp >= minc, {tag, " bits compared while locked"}, cmp, minc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lk [14];

        // R1: outputs quiet in reset
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(data == 1'b0,  "R1 data_o in reset", data, 0);
        check(valid == 1'b0, "R1 valid_o in reset", valid, 0);
        check(lock == 1'b0,  "R1 lock_o in reset", lock, 0);

        // R3/R5/R7: idle line, strobes at exact period, data 0, no lock
        do_reset(16);
        check(lock == 1'b0 && valid == 1'b0, "R1 outputs after release", {lock, valid}, 0);
        repeat (120) @(negedge clk);
        begin
            int gap_bad = 0;
            int ones = 0;
            for (int i = 1; i < nlog; i++) if (logt[i] - logt[i-1] != 16) gap_bad++;
            for (int i = 0; i < nlog; i++) if (logd[i]) ones++;
            check(nlog >= 6, "R3 idle strobe count", nlog, 6);
            check(gap_bad == 0, "R3 idle strobe spacing off period", gap_bad, 0);
            check(ones == 0, "R5 idle data ones", ones, 0);
            check(lock == 1'b0, "R7 no lock without edges", lock, 0);
        end

        // table of streams: R6 bits, R9 period, R7 lock at end
        for (int v = 0; v < NV; v++) begin
            do_reset(PER[v]);
            repeat (10) @(negedge clk);
            for (int i = 0; i < 24; i++) put_bit(1'b1, QPER[v]);
            for (int i = 31; i >= 0; i--) put_bit(PAT[v][i], QPER[v]);
            for (int i = 0; i < 4; i++) put_bit(1'b1, QPER[v]);
            repeat (3 * PER[v]) @(negedge clk);
            score($sformatf("R6 R9 vector %0d", v), 36);
            check(lock == 1'b1, $sformatf("R7 lock after vector %0d", v), lock, 1);
        end

        // R2: a line held high over three cells gives 1,0,0
        do_reset(16);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 24; i++) put_cell(1'b1, 16, 8);
        put_cell(1'b1, 16, 16);
        put_cell(1'b0, 16, 16);
        put_cell(1'b0, 16, 0);
        for (int i = 0; i < 4; i++) put_cell(1'b1, 16, 8);
        repeat (40) @(negedge clk);
        score("R2 R5 held-high line", 8);

        // R8 then R7: phase jump of 7 clocks after lock
        do_reset(16);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 24; i++) put_cell(1'b1, 16, 8);
        check(lock == 1'b1, "R7 locked before jump", lock, 1);
        repeat (7) @(negedge clk);
        for (int n = 1; n <= 13; n++) begin
            put_cell(1'b1, 16, 8);
            lk[n] = int'(lock);
        end
        check(lk[3] == 1,  "R8 lock kept after 3 late edges", lk[3], 1);
        check(lk[4] == 0,  "R8 lock lost on 4th late edge", lk[4], 0);
        check(lk[12] == 0, "R7 lock absent after 7 good edges", lk[12], 0);
        check(lk[13] == 1, "R7 lock regained on 8th good edge", lk[13], 1);

        // R3/R4: spacing while locked stayed within one cycle of the period
        check(sp_bad == 0, "R3 R4 locked strobe spacing violations", sp_worst, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule